// File: doc/BRIEF.md
# BCD Calendar Clock with Hundredths Resolution

This block is a synchronous timekeeping core. A periodic single-cycle `tick` enable drives it. Every `TICKS_PER_CENT` accepted ticks it advances a BCD time of day with hundredths of a second, together with a day of week, a date, a month and a two-digit year. The date wraps at the correct length for each month, and February gets a 29th day when the year is a multiple of four. The hours field runs in either 24-hour or 12-hour form; the 12-hour form carries an AM/PM flag.

A serial access unit writes all fields at once through a parallel load port. It reads the current time from a registered 64-bit snapshot output, laid out with the same field positions as the load port. A halt input makes the core ignore ticks. When the host does not tick the core, all fields hold.

Top module: `bcd_calendar_core`

## Requirements
- R1: Reset (synchronous, active high) sets year 00, month 01, date 01, day of week 01, hours 00 in 24-hour mode, and minutes, seconds and hundredths to 00.
- R2: Hundredths advance by one after every `TICKS_PER_CENT` accepted ticks. The value 99 wraps to 00 and carries into seconds. With no tick and no load, the snapshot holds.
- R3: Seconds and minutes each wrap from 59 to 00, and each wrap carries into the next field.
- R4: In 24-hour mode (hours byte bit 7 = 0, BCD hours in bits 5:0), hours run 00 to 23. The step from 23 to 00 carries into date and day of week.
- R5: In 12-hour mode (bit 7 = 1, PM flag in bit 5, BCD hours in bits 4:0), hours run 12, 01, …, 11. The PM flag toggles on the step from 11 to 12. Date and day of week advance only on the step from 11 PM to 12 AM.
- R6: Dates in months 04, 06, 09 and 11 wrap after 30. Dates in all other months except 02 wrap after 31. A wrap returns the date to 01 and advances the month, with BCD carry (09 to 10).
- R7: In month 02 the date wraps after 29 when the BCD year is divisible by four, and after 28 otherwise.
- R8: Month 12 wraps to 01 and advances the year. The year wraps from 99 to 00.
- R9: Day of week runs 01 to 07. It advances at each midnight and wraps from 07 to 01.
- R10: A load pulse writes all fields from `load_val` in the next cycle. The load wins over a tick in the same cycle and clears the partial tick count.
- R11: While `halt` is high, ticks are ignored and do not count toward the next hundredth.
- R12: The snapshot and load word place the fields as follows: hundredths [7:0], seconds [15:8], minutes [23:16], hours [31:24], day of week [39:32], date [47:40], month [55:48], year [63:56].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Single-cycle timebase enable |
| halt | input | 1 | When high, ticks are ignored |
| load | input | 1 | Writes all fields from `load_val` |
| load_val | input | 64 | Packed field values to load |
| snap | output | 64 | Registered snapshot of all fields |

## Verification
The bench builds the core with `TICKS_PER_CENT` = 2. This setting makes the prescaler observable: a single tick after a load must leave the time unchanged. Halted ticks and a tick that coincides with a load must not leave a half-count behind. Every rollover case starts from a loaded value, so midnight, month ends, leap Februaries and the century wrap are each reached within a few cycles.

// File: rtl/caltime_pkg.sv
package caltime_pkg;

  localparam int FIELD_W = 8;
  localparam int CAL_W   = 8 * FIELD_W;

  localparam int HOUR_MODE12_BIT = 7;
  localparam int HOUR_PM_BIT     = 5;

  typedef struct packed {
    logic [FIELD_W-1:0] year;
    logic [FIELD_W-1:0] month;
    logic [FIELD_W-1:0] date;
    logic [FIELD_W-1:0] dow;
    logic [FIELD_W-1:0] hour;
    logic [FIELD_W-1:0] min;
    logic [FIELD_W-1:0] sec;
    logic [FIELD_W-1:0] cent;
  } cal_t;

  localparam cal_t CAL_RESET = '{
    year:  8'h00, month: 8'h01, date: 8'h01, dow: 8'h01,
    hour:  8'h00, min:   8'h00, sec:  8'h00, cent: 8'h00
  };

  function automatic logic [FIELD_W-1:0] bcd_inc(input logic [FIELD_W-1:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    else                return {v[7:4], v[3:0] + 4'd1};
  endfunction

endpackage

// File: rtl/cal_bcd_step.sv
module cal_bcd_step
  import caltime_pkg::*;
(
  input  logic [FIELD_W-1:0] cur,
  input  logic [FIELD_W-1:0] lo,
  input  logic [FIELD_W-1:0] hi,
  output logic [FIELD_W-1:0] nxt,
  output logic               wrap
);
  always_comb begin
    wrap = (cur >= hi);
    nxt  = wrap ? lo : bcd_inc(cur);
  end
endmodule

// File: rtl/cal_month_days.sv
module cal_month_days
  import caltime_pkg::*;
(
  input  logic [FIELD_W-1:0] month,
  input  logic [FIELD_W-1:0] year,
  output logic [FIELD_W-1:0] last_day
);
  logic leap;

  // BCD year divisible by four: even tens with units 0/4/8, odd tens with units 2/6
  always_comb begin
    if (year[4] == 1'b0) leap = (year[3:0] == 4'd0) || (year[3:0] == 4'd4) || (year[3:0] == 4'd8);
    else                 leap = (year[3:0] == 4'd2) || (year[3:0] == 4'd6);
  end

  always_comb begin
    case (month)
      8'h02:                      last_day = leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: last_day = 8'h30;
      default:                    last_day = 8'h31;
    endcase
  end
endmodule

// File: rtl/cal_hour_step.sv
module cal_hour_step
  import caltime_pkg::*;
(
  input  logic [FIELD_W-1:0] cur,
  output logic [FIELD_W-1:0] nxt,
  output logic               day_wrap
);
  logic       mode12;
  logic       pm;
  logic [4:0] h12;
  logic [5:0] h24;

  assign mode12 = cur[HOUR_MODE12_BIT];
  assign pm     = cur[HOUR_PM_BIT];
  assign h12    = cur[4:0];
  assign h24    = cur[5:0];

  always_comb begin
    nxt      = cur;
    day_wrap = 1'b0;
    if (mode12) begin
      if (h12 == 5'h11) begin
        nxt[4:0]         = 5'h12;
        nxt[HOUR_PM_BIT] = ~pm;
        day_wrap         = pm;
      end else if (h12 >= 5'h12) begin
        nxt[4:0] = 5'h01;
      end else if (h12[3:0] >= 4'd9) begin
        nxt[4:0] = 5'h10;
      end else begin
        nxt[3:0] = h12[3:0] + 4'd1;
      end
    end else begin
      if (h24 >= 6'h23) begin
        nxt[5:0] = 6'h00;
        day_wrap = 1'b1;
      end else if (h24[3:0] >= 4'd9) begin
        nxt[5:0] = {h24[5:4] + 2'd1, 4'd0};
      end else begin
        nxt[3:0] = h24[3:0] + 4'd1;
      end
    end
  end
endmodule

// File: rtl/bcd_calendar_core.sv
module bcd_calendar_core
  import caltime_pkg::*;
#(
  parameter int TICKS_PER_CENT = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             halt,
  input  logic             load,
  input  logic [CAL_W-1:0] load_val,
  output logic [CAL_W-1:0] snap
);
  localparam int PW     = (TICKS_PER_CENT > 1) ? $clog2(TICKS_PER_CENT) : 1;
  localparam int N_LOW  = 3;   // hundredths, seconds, minutes
  localparam logic [FIELD_W-1:0] LOW_HI [N_LOW] = '{8'h99, 8'h59, 8'h59};

  cal_t          regs, regs_nxt;
  logic [PW-1:0] pre_cnt;
  logic          pre_last;
  logic          adv;

  // ---------------- tick prescaler ----------------
  assign pre_last = (pre_cnt == PW'(TICKS_PER_CENT - 1));
  assign adv      = tick && !halt && !load && pre_last;

  always_ff @(posedge clk) begin
    if (rst || load)               pre_cnt <= '0;
    else if (tick && !halt)        pre_cnt <= pre_last ? '0 : pre_cnt + PW'(1);
  end

  // ---------------- low fields: carry chain ----------------
  logic [N_LOW:0]       carry;
  logic [FIELD_W-1:0]   low_nxt  [N_LOW];
  logic [N_LOW-1:0]     low_wrap;

  assign carry[0] = adv;

  for (genvar i = 0; i < N_LOW; i++) begin : g_low
    cal_bcd_step u_step (
      .cur  (regs[i*FIELD_W +: FIELD_W]),
      .lo   (8'h00),
      .hi   (LOW_HI[i]),
      .nxt  (low_nxt[i]),
      .wrap (low_wrap[i])
    );
    assign carry[i+1] = carry[i] && low_wrap[i];
  end

  // ---------------- hours ----------------
  logic [FIELD_W-1:0] hour_nxt;
  logic               hour_day;
  logic               day_carry;

  cal_hour_step u_hour (.cur(regs.hour), .nxt(hour_nxt), .day_wrap(hour_day));
  assign day_carry = carry[N_LOW] && hour_day;

  // ---------------- calendar ----------------
  logic [FIELD_W-1:0] last_day;
  logic [FIELD_W-1:0] date_nxt, dow_nxt, month_nxt, year_nxt;
  logic               date_wrap, dow_wrap, month_wrap, year_wrap;
  logic               month_carry, year_carry;

  cal_month_days u_mlen (.month(regs.month), .year(regs.year), .last_day(last_day));

  cal_bcd_step u_date  (.cur(regs.date),  .lo(8'h01), .hi(last_day), .nxt(date_nxt),  .wrap(date_wrap));
  cal_bcd_step u_dow   (.cur(regs.dow),   .lo(8'h01), .hi(8'h07),    .nxt(dow_nxt),   .wrap(dow_wrap));
  cal_bcd_step u_month (.cur(regs.month), .lo(8'h01), .hi(8'h12),    .nxt(month_nxt), .wrap(month_wrap));
  cal_bcd_step u_year  (.cur(regs.year),  .lo(8'h00), .hi(8'h99),    .nxt(year_nxt),  .wrap(year_wrap));

  assign month_carry = day_carry && date_wrap;
  assign year_carry  = month_carry && month_wrap;

  always_comb begin
    regs_nxt = regs;
    for (int i = 0; i < N_LOW; i++)
      if (carry[i]) regs_nxt[i*FIELD_W +: FIELD_W] = low_nxt[i];
    if (carry[N_LOW]) regs_nxt.hour  = hour_nxt;
    if (day_carry)    regs_nxt.date  = date_nxt;
    if (day_carry)    regs_nxt.dow   = dow_nxt;
    if (month_carry)  regs_nxt.month = month_nxt;
    if (year_carry)   regs_nxt.year  = year_nxt;
  end

  always_ff @(posedge clk) begin
    if (rst)       regs <= CAL_RESET;
    else if (load) regs <= cal_t'(load_val);
    else           regs <= regs_nxt;
  end

  assign snap = regs;

  // ---------------- assertions ----------------
  a_r10_load_wins: assert property (@(posedge clk) disable iff (rst)
    load |=> snap == $past(load_val));

  a_r11_halt_freeze: assert property (@(posedge clk) disable iff (rst)
    (halt && !load) |=> $stable(snap));

  a_r2_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (!tick && !load) |=> $stable(snap));

  a_r2_cent_wrap: assert property (@(posedge clk) disable iff (rst)
    (adv && snap[7:0] == 8'h99) |=> (snap[7:0] == 8'h00));

  a_r9_dow_wrap: assert property (@(posedge clk) disable iff (rst)
    (day_carry && snap[39:32] == 8'h07) |=> (snap[39:32] == 8'h01));

  a_r8_year_wrap: assert property (@(posedge clk) disable iff (rst)
    (year_carry && snap[63:56] == 8'h99) |=> (snap[63:56] == 8'h00));

endmodule

// File: tb/bcd_calendar_core_tb.sv
`timescale 1ns/1ps
module bcd_calendar_core_tb;

  localparam int TPC = 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0;
  logic        halt = 1'b0;
  logic        load = 1'b0;
  logic [63:0] load_val = '0;
  logic [63:0] snap;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #10 clk = ~clk;   // 50 MHz

  bcd_calendar_core #(.TICKS_PER_CENT(TPC)) u_dut (
    .clk(clk), .rst(rst), .tick(tick), .halt(halt),
    .load(load), .load_val(load_val), .snap(snap)
  );

  typedef struct packed {
    logic [63:0] start;
    logic [63:0] expv;
    logic [7:0]  n;
    logic [7:0]  req;
  } vec_t;

  // word layout: year_month_date_dow_hour_min_sec_cent
  localparam int NV = 24;
  localparam vec_t VEC [NV] = '{
    '{64'h00_01_01_01_00_00_00_00, 64'h00_01_01_01_00_00_00_00, 8'd1, 8'd2},  // R2 half count
    '{64'h00_01_01_01_00_00_00_00, 64'h00_01_01_01_00_00_00_01, 8'd2, 8'd2},  // R2
    '{64'h24_03_15_03_10_20_30_99, 64'h24_03_15_03_10_20_31_00, 8'd2, 8'd2},  // R2 cent wrap
    '{64'h24_03_15_03_10_20_30_09, 64'h24_03_15_03_10_20_30_10, 8'd2, 8'd2},  // R2 bcd carry
    '{64'h24_03_15_03_10_20_59_99, 64'h24_03_15_03_10_21_00_00, 8'd2, 8'd3},  // R3
    '{64'h24_03_15_03_10_59_59_99, 64'h24_03_15_03_11_00_00_00, 8'd2, 8'd3},  // R3
    '{64'h24_03_15_03_23_59_59_99, 64'h24_03_16_04_00_00_00_00, 8'd2, 8'd4},  // R4 midnight
    '{64'h24_03_15_03_09_59_59_99, 64'h24_03_15_03_10_00_00_00, 8'd2, 8'd4},  // R4
    '{64'h24_03_15_03_19_59_59_99, 64'h24_03_15_03_20_00_00_00, 8'd2, 8'd4},  // R4
    '{64'h24_03_15_03_91_59_59_99, 64'h24_03_15_03_B2_00_00_00, 8'd2, 8'd5},  // R5 11AM->12PM
    '{64'h24_03_15_03_B2_59_59_99, 64'h24_03_15_03_A1_00_00_00, 8'd2, 8'd5},  // R5 12PM->1PM
    '{64'h24_03_15_03_B1_59_59_99, 64'h24_03_16_04_92_00_00_00, 8'd2, 8'd5},  // R5 11PM->12AM
    '{64'h24_03_15_03_92_59_59_99, 64'h24_03_15_03_81_00_00_00, 8'd2, 8'd5},  // R5 12AM->1AM
    '{64'h24_03_15_03_89_59_59_99, 64'h24_03_15_03_90_00_00_00, 8'd2, 8'd5},  // R5 9->10
    '{64'h24_04_30_02_23_59_59_99, 64'h24_05_01_03_00_00_00_00, 8'd2, 8'd6},  // R6 30-day
    '{64'h24_01_30_02_23_59_59_99, 64'h24_01_31_03_00_00_00_00, 8'd2, 8'd6},  // R6 31-day
    '{64'h24_09_30_02_23_59_59_99, 64'h24_10_01_03_00_00_00_00, 8'd2, 8'd6},  // R6 month 09->10
    '{64'h23_02_28_02_23_59_59_99, 64'h23_03_01_03_00_00_00_00, 8'd2, 8'd7},  // R7 common
    '{64'h24_02_28_02_23_59_59_99, 64'h24_02_29_03_00_00_00_00, 8'd2, 8'd7},  // R7 leap
    '{64'h24_02_29_02_23_59_59_99, 64'h24_03_01_03_00_00_00_00, 8'd2, 8'd7},  // R7 leap end
    '{64'h12_02_28_02_23_59_59_99, 64'h12_02_29_03_00_00_00_00, 8'd2, 8'd7},  // R7 odd tens
    '{64'h10_02_28_02_23_59_59_99, 64'h10_03_01_03_00_00_00_00, 8'd2, 8'd7},  // R7 year 10
    '{64'h99_12_31_02_23_59_59_99, 64'h00_01_01_03_00_00_00_00, 8'd2, 8'd8},  // R8 century
    '{64'h24_03_15_07_23_59_59_99, 64'h24_03_16_01_00_00_00_00, 8'd2, 8'd9}   // R9 dow wrap
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] expv);
    n_checks++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic do_load(input logic [63:0] v);
    @(negedge clk); load = 1'b1; load_val = v;
    @(negedge clk); load = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state, R12 field positions
    check("R1", snap, 64'h00_01_01_01_00_00_00_00);
    check("R12", {56'h0, snap[39:32]}, 64'h01);

    // table walk
    for (int i = 0; i < NV; i++) begin
      do_load(VEC[i].start);
      ticks(int'(VEC[i].n));
      check($sformatf("R%0d vec%0d", VEC[i].req, i), snap, VEC[i].expv);
    end

    // R12: advancing hundredths touches only bits [7:0]
    do_load(64'h55_06_14_05_07_33_44_20);
    ticks(2);
    check("R12", snap, 64'h55_06_14_05_07_33_44_21);

    // R11 halt: ticks ignored, and not counted
    do_load(64'h24_03_15_03_10_20_30_40);
    @(negedge clk); halt = 1'b1;
    ticks(5);
    check("R11", snap, 64'h24_03_15_03_10_20_30_40);
    @(negedge clk); halt = 1'b0;
    ticks(1);
    check("R11", snap, 64'h24_03_15_03_10_20_30_40);
    ticks(1);
    check("R11", snap, 64'h24_03_15_03_10_20_30_41);

    // R10 load beats tick and clears partial count
    do_load(64'h24_03_15_03_10_20_30_40);
    ticks(1);
    @(negedge clk); load = 1'b1; tick = 1'b1; load_val = 64'h30_07_04_02_08_15_25_50;
    @(negedge clk); load = 1'b0; tick = 1'b0;
    check("R10", snap, 64'h30_07_04_02_08_15_25_50);
    ticks(1);
    check("R10", snap, 64'h30_07_04_02_08_15_25_50);
    ticks(1);
    check("R10", snap, 64'h30_07_04_02_08_15_25_51);

    // R2 idle: no ticks, value holds
    repeat (5) @(negedge clk);
    check("R2", snap, 64'h30_07_04_02_08_15_25_51);

    // R8 year carry on December 31
    do_load(64'h24_12_31_02_23_59_59_99);
    ticks(2);
    check("R8", snap, 64'h25_01_01_03_00_00_00_00);

    // R1 reset during operation
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check("R1", snap, 64'h00_01_01_01_00_00_00_00);

    finish_run();
  end

endmodule